// File: doc/BRIEF.md
# ASID-Tagged Multi-Way Translation Lookaside Buffer

This block translates a 32-bit virtual address into a physical address by searching seven TLB ways at once. Four ways hold 4 KB pages and are set-indexed by the low page-number bits. One way has a page size chosen at run time from 1, 4, 16 or 64 MB. Two ways are fixed: they hold preset 128 MB and 256 MB mappings that software cannot rewrite. Each entry carries an 8-bit address-space tag. A four-slot tag register maps each tag onto a privilege ring, and that mapping decides whether an entry may hit.

A lookup arrives on a valid/ready request channel with a virtual address and an access kind (load, store or fetch). One cycle later the result is held on a valid/ready response channel until it is taken. A request is accepted only when the response register is empty or is being drained in the same cycle, so a stalled consumer holds back new lookups without losing one. The result is a hit, a miss, a multi-hit fault, or a privilege or permission fault, each with a cause code. A hit also returns the physical address, the page size, the access rights and the cache policy. Software writes and refills enter through a single entry-write port. Separate plain control pins load the tag register, the variable-way page-size code and the current privilege ring.

Top module: `tlb_xlate_top`

## Requirements
- R1: After reset the response channel is empty and `req_ready` is 1. The tag register holds 0x04030201, so ring r holds tag r+1. Every entry in ways 0 to 4 has tag 0, so a lookup that only those ways could serve misses.
- R2: A write to the tag register stores bits 31:8 as given and forces bits 7:0 (ring 0) to 0x01. Ring r's tag is bits 8r+7..8r.
- R3: An entry with tag 0 never hits. A nonzero tag hits only if the page-number bits match and the tag equals one of the four ring slots. The reported ring is the lowest matching slot number. A tag found in no slot gives a miss.
- R4: Ways 0 to 3 map 4 KB pages (mask 0xFFFFF000). With REFILL_ENTRIES=4 they are indexed by vaddr bits 13:12, and with 8 by bits 14:12.
- R5: Way 4 uses the 2-bit size code c written through `pgsz_wdata`. Its mask is 0xFFF00000 shifted left by 2c, and its 2-bit index is taken at bit 20+2c. The mask is applied at lookup time, so a changed code takes effect at once.
- R6: Way 5 (128 MB, index bit 27) holds 0xD0000000->0x00000000 with attribute 7 and 0xD8000000->0x00000000 with attribute 3. Way 6 (256 MB, index bit 28) holds 0xE0000000->0xF0000000 with attribute 7 and 0xF0000000->0xF0000000 with attribute 3. All four have tag 1. Entry writes to ways 5 and 6 have no effect.
- R7: Response status is 0 hit, 1 miss, 2 multi-hit, 3 fault. Two or more hitting ways give a multi-hit: cause 17 for a fetch, 25 for a load or store. No hitting way gives a miss: 16 for a fetch, 24 for a load or store. On any non-hit the address, size, rights, cache, ring and way outputs are 0.
- R8: A single hit whose ring is below `cur_ring` gives a fault with cause 18 for a fetch and 26 for a load or store. This check comes before the permission check.
- R9: Attribute codes below 12 grant read. Bit 0 grants execute and bit 1 grants write. Bits 3:2 give the cache policy: 00 bypass (0), 01 write-back (1), 10 write-through (2). Code 13 grants read and write with policy isolate (3). Every other code grants nothing.
- R10: A fetch (`req_kind[1]`=1) drops read and write and needs execute. A load (`req_kind`=00) drops execute and needs read. A store (`req_kind`=01) drops execute and needs write. A missing right gives a fault with cause 20 for a fetch, 28 for a load and 29 for a store.
- R11: On a hit, cause is 0 and the rights shown are those left after dropping. The physical address is (entry physical page AND mask) OR (vaddr AND NOT mask). The page size is NOT mask plus 1.
- R12: `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. A response held with `rsp_ready` low keeps all its fields stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| asid_we | input | 1 | Load the ring tag register |
| asid_wdata | input | 32 | New tag register value (bits 7:0 ignored) |
| pgsz_we | input | 1 | Load the variable-way size code |
| pgsz_wdata | input | 2 | Size code for way 4 |
| cur_ring | input | 2 | Current privilege ring |
| ent_we | input | 1 | Entry write strobe |
| ent_way | input | 3 | Target way |
| ent_idx | input | IDXW | Target entry within the way |
| ent_vpn | input | 32 | Virtual page number of the entry |
| ent_ppn | input | 32 | Physical page number of the entry |
| ent_asid | input | 8 | Address-space tag of the entry |
| ent_attr | input | 4 | Attribute code of the entry |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | 00 load, 01 store, 1x fetch |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result taken |
| rsp_status | output | 2 | 0 hit, 1 miss, 2 multi-hit, 3 fault |
| rsp_cause | output | 6 | Cause code, 0 on hit |
| rsp_paddr | output | 32 | Physical address |
| rsp_pgsize | output | 32 | Page size in bytes |
| rsp_rd | output | 1 | Read right |
| rsp_wr | output | 1 | Write right |
| rsp_ex | output | 1 | Execute right |
| rsp_cache | output | 2 | 0 bypass, 1 write-back, 2 write-through, 3 isolate |
| rsp_ring | output | 2 | Ring of the hitting entry |
| rsp_way | output | 3 | Way of the hitting entry |

## Verification
The cycle assertions cover the response handshake. They check that a held result stays stable and that a full, stalled register refuses requests. They also check that every hit reports a power-of-two page size, cause 0 and at least one right. They check that rights never mix execute with read or write, that isolate hits carry both read and write, and that non-hits carry no address and no rights. Only the bench scenarios can show the translation itself. That covers which way hits for a given tag and ring-slot contents, the preset fixed-way mappings and the ignored writes to them, the variable page size, duplicate entries, the order between privilege and permission faults, and the full attribute table under each access kind.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;

  localparam int NUM_WAYS     = 7;
  localparam int NUM_VAR_WAYS = 5;

  typedef struct packed {
    logic [31:0] vpn;
    logic [31:0] ppn;
    logic [7:0]  asid;
    logic [3:0]  attr;
  } tlb_entry_t;

  typedef enum logic [1:0] {
    ST_HIT   = 2'd0,
    ST_MISS  = 2'd1,
    ST_MULTI = 2'd2,
    ST_FAULT = 2'd3
  } status_e;

  typedef enum logic [1:0] {
    CP_BYPASS = 2'd0,
    CP_WBACK  = 2'd1,
    CP_WTHRU  = 2'd2,
    CP_ISOL   = 2'd3
  } cache_e;

  localparam logic [5:0] CAUSE_I_MISS  = 6'd16;
  localparam logic [5:0] CAUSE_I_MULTI = 6'd17;
  localparam logic [5:0] CAUSE_I_PRIV  = 6'd18;
  localparam logic [5:0] CAUSE_I_PROH  = 6'd20;
  localparam logic [5:0] CAUSE_D_MISS  = 6'd24;
  localparam logic [5:0] CAUSE_D_MULTI = 6'd25;
  localparam logic [5:0] CAUSE_D_PRIV  = 6'd26;
  localparam logic [5:0] CAUSE_L_PROH  = 6'd28;
  localparam logic [5:0] CAUSE_S_PROH  = 6'd29;

  typedef struct packed {
    status_e     status;
    logic [5:0]  cause;
    logic [31:0] paddr;
    logic [31:0] pgsize;
    logic        rd;
    logic        wr;
    logic        ex;
    cache_e      cache;
    logic [1:0]  ring;
    logic [2:0]  way;
  } rsp_t;

  // Preset mappings of the two fixed ways (way 5: 128 MB, way 6: 256 MB).
  function automatic tlb_entry_t fixed_entry(input int way, input logic idx);
    tlb_entry_t e;
    e.asid = 8'd1;
    e.attr = idx ? 4'd3 : 4'd7;
    if (way == 5) begin
      e.vpn = idx ? 32'hD800_0000 : 32'hD000_0000;
      e.ppn = 32'h0000_0000;
    end else begin
      e.vpn = idx ? 32'hF000_0000 : 32'hE000_0000;
      e.ppn = 32'hF000_0000;
    end
    return e;
  endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_xlate_pkg::*;
#(
  parameter int REFILL_ENTRIES = 4,
  localparam int REF_IDXW = $clog2(REFILL_ENTRIES),
  localparam int IDXW     = (REF_IDXW > 2) ? REF_IDXW : 2,
  localparam int DEPTH    = 1 << IDXW
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [2:0]                             wr_way,
  input  logic [IDXW-1:0]                        wr_idx,
  input  tlb_entry_t                             wr_entry,
  input  logic [NUM_VAR_WAYS-1:0][IDXW-1:0]      rd_idx,
  output tlb_entry_t [NUM_VAR_WAYS-1:0]          rd_entry
);

  tlb_entry_t mem_q [NUM_VAR_WAYS][DEPTH];
  logic [IDXW-1:0] wr_slot;

  always_comb begin
    if (wr_way == 3'd4) wr_slot = IDXW'(wr_idx[1:0]);
    else                wr_slot = IDXW'(wr_idx[REF_IDXW-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_VAR_WAYS; w++)
        for (int e = 0; e < DEPTH; e++)
          mem_q[w][e] <= '0;
    end else if (wr_en && (wr_way < 3'(NUM_VAR_WAYS))) begin
      mem_q[wr_way][wr_slot] <= wr_entry;
    end
  end

  for (genvar w = 0; w < NUM_VAR_WAYS; w++) begin : g_rd
    assign rd_entry[w] = mem_q[w][rd_idx[w]];
  end

endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match
  import tlb_xlate_pkg::*;
(
  input  tlb_entry_t  ent,
  input  logic [31:0] mask,
  input  logic [31:0] vaddr,
  input  logic [31:0] ring_tags,
  output logic        hit,
  output logic [1:0]  ring
);

  logic [3:0] slot_eq;
  logic       tag_eq;

  always_comb begin
    for (int s = 0; s < 4; s++)
      slot_eq[s] = (ring_tags[8*s +: 8] == ent.asid);
    ring = 2'd0;
    for (int s = 3; s >= 0; s--)
      if (slot_eq[s]) ring = 2'(s);
    tag_eq = (((ent.vpn ^ vaddr) & mask) == 32'd0);
    hit    = (ent.asid != 8'd0) && tag_eq && (|slot_eq);
  end

endmodule

// File: rtl/tlb_attr_decode.sv
module tlb_attr_decode
  import tlb_xlate_pkg::*;
(
  input  logic [3:0] attr,
  input  logic       is_fetch,
  output logic       rd,
  output logic       wr,
  output logic       ex,
  output cache_e     cache
);

  logic raw_rd, raw_wr, raw_ex;

  always_comb begin
    raw_rd = 1'b0;
    raw_wr = 1'b0;
    raw_ex = 1'b0;
    cache  = CP_BYPASS;
    if (attr < 4'd12) begin
      raw_rd = 1'b1;
      raw_ex = attr[0];
      raw_wr = attr[1];
      unique case (attr[3:2])
        2'b00:   cache = CP_BYPASS;
        2'b01:   cache = CP_WBACK;
        default: cache = CP_WTHRU;
      endcase
    end else if (attr == 4'd13) begin
      raw_rd = 1'b1;
      raw_wr = 1'b1;
      cache  = CP_ISOL;
    end
    rd = raw_rd & ~is_fetch;
    wr = raw_wr & ~is_fetch;
    ex = raw_ex &  is_fetch;
  end

endmodule

// File: rtl/tlb_xlate_top.sv
module tlb_xlate_top
  import tlb_xlate_pkg::*;
#(
  parameter int REFILL_ENTRIES = 4,
  localparam int REF_IDXW = $clog2(REFILL_ENTRIES),
  localparam int IDXW     = (REF_IDXW > 2) ? REF_IDXW : 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            asid_we,
  input  logic [31:0]     asid_wdata,
  input  logic            pgsz_we,
  input  logic [1:0]      pgsz_wdata,
  input  logic [1:0]      cur_ring,
  input  logic            ent_we,
  input  logic [2:0]      ent_way,
  input  logic [IDXW-1:0] ent_idx,
  input  logic [31:0]     ent_vpn,
  input  logic [31:0]     ent_ppn,
  input  logic [7:0]      ent_asid,
  input  logic [3:0]      ent_attr,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [31:0]     req_vaddr,
  input  logic [1:0]      req_kind,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [1:0]      rsp_status,
  output logic [5:0]      rsp_cause,
  output logic [31:0]     rsp_paddr,
  output logic [31:0]     rsp_pgsize,
  output logic            rsp_rd,
  output logic            rsp_wr,
  output logic            rsp_ex,
  output logic [1:0]      rsp_cache,
  output logic [1:0]      rsp_ring,
  output logic [2:0]      rsp_way
);

  // Control registers
  logic [31:0] ring_tags_q;
  logic [1:0]  pgsz_q;
  logic        unused_tag_low;

  assign unused_tag_low = ^asid_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_tags_q <= 32'h0403_0201;
      pgsz_q      <= 2'd0;
    end else begin
      if (asid_we) ring_tags_q <= {asid_wdata[31:8], 8'h01};
      if (pgsz_we) pgsz_q      <= pgsz_wdata;
    end
  end

  // Entry storage for the writable ways
  tlb_entry_t                        wr_entry;
  logic [NUM_VAR_WAYS-1:0][IDXW-1:0] store_idx;
  tlb_entry_t [NUM_VAR_WAYS-1:0]     store_ent;

  assign wr_entry = '{vpn: ent_vpn, ppn: ent_ppn, asid: ent_asid, attr: ent_attr};

  tlb_entry_store #(.REFILL_ENTRIES(REFILL_ENTRIES)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ent_we),
    .wr_way   (ent_way),
    .wr_idx   (ent_idx),
    .wr_entry (wr_entry),
    .rd_idx   (store_idx),
    .rd_entry (store_ent)
  );

  // Per-way geometry and tag compare
  logic [NUM_WAYS-1:0][31:0] way_mask;
  tlb_entry_t [NUM_WAYS-1:0] way_ent;
  logic [NUM_WAYS-1:0]       way_hit;
  logic [NUM_WAYS-1:0][1:0]  way_ring;
  logic [4:0]                var_base;

  assign var_base = 5'd20 + 5'({pgsz_q, 1'b0});

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    if (w < 4) begin : g_small
      assign way_mask[w]  = 32'hFFFF_F000;
      assign store_idx[w] = IDXW'(req_vaddr[12 +: REF_IDXW]);
      assign way_ent[w]   = store_ent[w];
    end else if (w == 4) begin : g_var
      assign way_mask[w]  = 32'hFFF0_0000 << {pgsz_q, 1'b0};
      assign store_idx[w] = IDXW'(req_vaddr[var_base +: 2]);
      assign way_ent[w]   = store_ent[w];
    end else if (w == 5) begin : g_fix5
      assign way_mask[w]  = 32'hF800_0000;
      assign way_ent[w]   = fixed_entry(5, req_vaddr[27]);
    end else begin : g_fix6
      assign way_mask[w]  = 32'hF000_0000;
      assign way_ent[w]   = fixed_entry(6, req_vaddr[28]);
    end

    tlb_way_match match_i (
      .ent       (way_ent[w]),
      .mask      (way_mask[w]),
      .vaddr     (req_vaddr),
      .ring_tags (ring_tags_q),
      .hit       (way_hit[w]),
      .ring      (way_ring[w])
    );
  end

  // Hit selection
  logic [2:0]  hit_cnt;
  logic [2:0]  sel_way;
  logic [31:0] sel_mask;
  logic [31:0] sel_ppn;
  logic [3:0]  sel_attr;
  logic [1:0]  sel_ring;

  always_comb begin
    hit_cnt  = 3'($countones(way_hit));
    sel_way  = 3'd0;
    sel_mask = way_mask[0];
    sel_ppn  = way_ent[0].ppn;
    sel_attr = way_ent[0].attr;
    sel_ring = way_ring[0];
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        sel_way  = 3'(w);
        sel_mask = way_mask[w];
        sel_ppn  = way_ent[w].ppn;
        sel_attr = way_ent[w].attr;
        sel_ring = way_ring[w];
      end
    end
  end

  // Rights and result
  logic   is_fetch, is_store;
  logic   dec_rd, dec_wr, dec_ex;
  cache_e dec_cache;
  logic   granted;
  rsp_t   nxt, rsp_q;
  logic   rsp_valid_q;

  assign is_fetch = req_kind[1];
  assign is_store = (req_kind == 2'b01);

  tlb_attr_decode attr_i (
    .attr     (sel_attr),
    .is_fetch (is_fetch),
    .rd       (dec_rd),
    .wr       (dec_wr),
    .ex       (dec_ex),
    .cache    (dec_cache)
  );

  assign granted = is_fetch ? dec_ex : (is_store ? dec_wr : dec_rd);

  always_comb begin
    nxt = '0;
    if (hit_cnt == 3'd0) begin
      nxt.status = ST_MISS;
      nxt.cause  = is_fetch ? CAUSE_I_MISS : CAUSE_D_MISS;
    end else if (hit_cnt > 3'd1) begin
      nxt.status = ST_MULTI;
      nxt.cause  = is_fetch ? CAUSE_I_MULTI : CAUSE_D_MULTI;
    end else if (sel_ring < cur_ring) begin
      nxt.status = ST_FAULT;
      nxt.cause  = is_fetch ? CAUSE_I_PRIV : CAUSE_D_PRIV;
    end else if (!granted) begin
      nxt.status = ST_FAULT;
      nxt.cause  = is_fetch ? CAUSE_I_PROH : (is_store ? CAUSE_S_PROH : CAUSE_L_PROH);
    end else begin
      nxt.status = ST_HIT;
      nxt.paddr  = (sel_ppn & sel_mask) | (req_vaddr & ~sel_mask);
      nxt.pgsize = ~sel_mask + 32'd1;
      nxt.rd     = dec_rd;
      nxt.wr     = dec_wr;
      nxt.ex     = dec_ex;
      nxt.cache  = dec_cache;
      nxt.ring   = sel_ring;
      nxt.way    = sel_way;
    end
  end

  // Response register with valid/ready hand-off
  assign req_ready = !rsp_valid_q || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_q       <= '0;
    end else if (req_valid && req_ready) begin
      rsp_valid_q <= 1'b1;
      rsp_q       <= nxt;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_status = rsp_q.status;
  assign rsp_cause  = rsp_q.cause;
  assign rsp_paddr  = rsp_q.paddr;
  assign rsp_pgsize = rsp_q.pgsize;
  assign rsp_rd     = rsp_q.rd;
  assign rsp_wr     = rsp_q.wr;
  assign rsp_ex     = rsp_q.ex;
  assign rsp_cache  = rsp_q.cache;
  assign rsp_ring   = rsp_q.ring;
  assign rsp_way    = rsp_q.way;

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [1:0]  rsp_status,
  input logic [5:0]  rsp_cause,
  input logic [31:0] rsp_paddr,
  input logic [31:0] rsp_pgsize,
  input logic        rsp_rd,
  input logic        rsp_wr,
  input logic        rsp_ex,
  input logic [1:0]  rsp_cache
);

  assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) &&
                                   $stable(rsp_cause) && $stable(rsp_paddr)));

  assert_stall_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_rise_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid));

  assert_pow2_size_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd0) |-> ($countones(rsp_pgsize) == 1 && rsp_cause == 6'd0));

  assert_hit_has_right_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd0) |-> (rsp_rd || rsp_wr || rsp_ex));

  assert_isolate_rw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd0 && rsp_cache == 2'd3) |-> (rsp_rd && rsp_wr));

  assert_side_strip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_ex && (rsp_rd || rsp_wr)));

  assert_nonhit_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd0) |-> (rsp_cause != 6'd0 && rsp_paddr == 32'd0 &&
                                          !rsp_rd && !rsp_wr && !rsp_ex));

endmodule

bind tlb_xlate_top tlb_xlate_chk chk_i (.*);

// File: tb/tlb_xlate_top_tb_top.sv
module tlb_xlate_top_tb_top;

  localparam int IDXW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            asid_we = 1'b0;
  logic [31:0]     asid_wdata = '0;
  logic            pgsz_we = 1'b0;
  logic [1:0]      pgsz_wdata = '0;
  logic [1:0]      cur_ring = '0;
  logic            ent_we = 1'b0;
  logic [2:0]      ent_way = '0;
  logic [IDXW-1:0] ent_idx = '0;
  logic [31:0]     ent_vpn = '0, ent_ppn = '0;
  logic [7:0]      ent_asid = '0;
  logic [3:0]      ent_attr = '0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [31:0]     req_vaddr = '0;
  logic [1:0]      req_kind = '0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic [1:0]      rsp_status;
  logic [5:0]      rsp_cause;
  logic [31:0]     rsp_paddr, rsp_pgsize;
  logic            rsp_rd, rsp_wr, rsp_ex;
  logic [1:0]      rsp_cache, rsp_ring;
  logic [2:0]      rsp_way;

  always #10 clk = ~clk;

  tlb_xlate_top dut_i (.*);

  typedef struct packed {
    logic [1:0]  st;
    logic [5:0]  cause;
    logic [31:0] pa;
    logic [31:0] ps;
    logic [2:0]  rwx;
    logic [1:0]  cache;
    logic [1:0]  ring;
    logic [2:0]  way;
  } exp_t;

  // Reference state
  logic [31:0] r_vpn  [5][4];
  logic [31:0] r_ppn  [5][4];
  logic [7:0]  r_asid [5][4];
  logic [3:0]  r_attr [5][4];
  logic [7:0]  r_slot [4];
  int          r_code;
  bit          m_valid;
  exp_t        m_exp;
  string       m_tag, cur_tag;
  int          n_cmp = 0, n_bad = 0;

  function automatic exp_t ref_lookup(input logic [31:0] va, input logic [1:0] kind,
                                      input logic [1:0] cur);
    exp_t r;
    int nh, hw, hring;
    logic [31:0] hmask, hppn;
    logic [3:0] hattr;
    logic rd, wr, ex, fetch, ok;
    logic [1:0] cp;
    r = '0; nh = 0; hw = 0; hring = 0; hmask = 0; hppn = 0; hattr = 0;
    for (int w = 0; w < 7; w++) begin
      logic [31:0] m, ev, ep;
      logic [7:0] ea;
      logic [3:0] et;
      int ix, rg;
      if (w < 4)       begin m = 32'hFFFFF000; ix = int'((va >> 12) & 3); end
      else if (w == 4) begin m = 32'hFFF00000 << (2 * r_code); ix = int'((va >> (20 + 2 * r_code)) & 3); end
      else if (w == 5) begin m = 32'hF8000000; ix = int'(va[27]); end
      else             begin m = 32'hF0000000; ix = int'(va[28]); end
      if (w < 5) begin
        ev = r_vpn[w][ix]; ep = r_ppn[w][ix]; ea = r_asid[w][ix]; et = r_attr[w][ix];
      end else if (w == 5) begin
        ev = (ix != 0) ? 32'hD8000000 : 32'hD0000000; ep = 0; ea = 1; et = (ix != 0) ? 3 : 7;
      end else begin
        ev = (ix != 0) ? 32'hF0000000 : 32'hE0000000; ep = 32'hF0000000; ea = 1; et = (ix != 0) ? 3 : 7;
      end
      rg = -1;
      for (int s = 3; s >= 0; s--) if (r_slot[s] == ea) rg = s;
      if (ea != 0 && rg >= 0 && ((ev & m) == (va & m))) begin
        nh++;
        if (nh == 1) begin hw = w; hring = rg; hmask = m; hppn = ep; hattr = et; end
      end
    end
    fetch = kind[1];
    rd = 0; wr = 0; ex = 0; cp = 0;
    if (hattr < 12) begin rd = 1; ex = hattr[0]; wr = hattr[1]; cp = hattr[3:2]; end
    else if (hattr == 13) begin rd = 1; wr = 1; cp = 3; end
    if (fetch) begin rd = 0; wr = 0; end else ex = 0;
    ok = fetch ? ex : ((kind == 2'b01) ? wr : rd);
    if (nh == 0) begin r.st = 1; r.cause = fetch ? 16 : 24; end
    else if (nh > 1) begin r.st = 2; r.cause = fetch ? 17 : 25; end
    else if (hring < int'(cur)) begin r.st = 3; r.cause = fetch ? 18 : 26; end
    else if (!ok) begin r.st = 3; r.cause = fetch ? 20 : ((kind == 2'b01) ? 29 : 28); end
    else begin
      r.st = 0; r.cause = 0;
      r.pa = (hppn & hmask) | (va & ~hmask);
      r.ps = ~hmask + 1;
      r.rwx = {rd, wr, ex};
      r.cache = cp; r.ring = 2'(hring); r.way = 3'(hw);
    end
    return r;
  endfunction

  always @(posedge clk) begin
    bit rdy;
    if (!rst_n) begin
      m_valid = 0;
      for (int w = 0; w < 5; w++)
        for (int e = 0; e < 4; e++) begin
          r_vpn[w][e] = 0; r_ppn[w][e] = 0; r_asid[w][e] = 0; r_attr[w][e] = 0;
        end
      for (int s = 0; s < 4; s++) r_slot[s] = 8'(s + 1);
      r_code = 0;
    end else begin
      rdy = !m_valid || rsp_ready;
      if (req_valid && rdy) begin
        m_exp = ref_lookup(req_vaddr, req_kind, cur_ring);
        m_valid = 1; m_tag = cur_tag;
      end else if (rsp_ready) m_valid = 0;
      if (ent_we && ent_way < 5) begin
        r_vpn[ent_way][ent_idx] = ent_vpn; r_ppn[ent_way][ent_idx] = ent_ppn;
        r_asid[ent_way][ent_idx] = ent_asid; r_attr[ent_way][ent_idx] = ent_attr;
      end
      if (asid_we)
        for (int s = 0; s < 4; s++) r_slot[s] = (s == 0) ? 8'h01 : asid_wdata[8*s +: 8];
      if (pgsz_we) r_code = int'(pgsz_wdata);
    end
  end

  task automatic cmp(input string tg, input string fld, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tg, fld, act, exp);
    end
  endtask

  task automatic check_all();
    if (!rst_n) return;
    cmp("R12", "rsp_valid", 32'(rsp_valid), 32'(m_valid));
    cmp("R12", "req_ready", 32'(req_ready), 32'(!m_valid || rsp_ready));
    if (m_valid) begin
      cmp(m_tag, "status", 32'(rsp_status), 32'(m_exp.st));
      cmp(m_tag, "cause", 32'(rsp_cause), 32'(m_exp.cause));
      cmp(m_tag, "paddr", rsp_paddr, m_exp.pa);
      cmp(m_tag, "pgsize", rsp_pgsize, m_exp.ps);
      cmp(m_tag, "rwx", 32'({rsp_rd, rsp_wr, rsp_ex}), 32'(m_exp.rwx));
      cmp(m_tag, "cache", 32'(rsp_cache), 32'(m_exp.cache));
      cmp(m_tag, "ring", 32'(rsp_ring), 32'(m_exp.ring));
      cmp(m_tag, "way", 32'(rsp_way), 32'(m_exp.way));
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check_all();
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] kind, input string tg);
    req_valid = 1; req_vaddr = va; req_kind = kind; cur_tag = tg;
    tick();
    req_valid = 0;
    tick();
  endtask

  task automatic put(input int way, input int idx, input logic [31:0] vpn, input logic [31:0] ppn,
                     input logic [7:0] asid, input logic [3:0] attr);
    ent_we = 1; ent_way = 3'(way); ent_idx = IDXW'(idx);
    ent_vpn = vpn; ent_ppn = ppn; ent_asid = asid; ent_attr = attr;
    tick();
    ent_we = 0;
  endtask

  // Exact expected values for key cases, independent of the model
  task automatic expect_direct(input string tg, input logic [1:0] st, input logic [5:0] cause,
                               input logic [31:0] pa);
    cmp(tg, "direct status", 32'(rsp_status), 32'(st));
    cmp(tg, "direct cause", 32'(rsp_cause), 32'(cause));
    cmp(tg, "direct paddr", rsp_paddr, pa);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1: reset state and empty refill ways
    cmp("R1", "reset rsp_valid", 32'(rsp_valid), 0);
    cmp("R1", "reset req_ready", 32'(req_ready), 1);
    req_valid = 1; req_vaddr = 32'h0000_1000; req_kind = 2; cur_tag = "R1";
    tick(); req_valid = 0;
    expect_direct("R1", 2'd1, 6'd16, 32'd0);
    tick();
    lookup(32'h0000_1000, 0, "R1");
    // R6: fixed way 5 preset, ring 0 tag 1
    req_valid = 1; req_vaddr = 32'hD000_1234; req_kind = 0; cur_tag = "R6";
    tick(); req_valid = 0;
    expect_direct("R6", 2'd0, 6'd0, 32'h0000_1234);
    tick();
    lookup(32'hD800_0040, 2, "R6");
    lookup(32'hE123_4567, 0, "R6");
    lookup(32'hF000_0008, 1, "R6");
    // R6: writes into fixed ways are ignored
    put(5, 0, 32'hD000_0000, 32'h1200_0000, 8'd2, 4'd0);
    put(6, 1, 32'hF000_0000, 32'h0000_0000, 8'd1, 4'd15);
    req_valid = 1; req_vaddr = 32'hD000_0010; req_kind = 0; cur_tag = "R6";
    tick(); req_valid = 0;
    expect_direct("R6", 2'd0, 6'd0, 32'h0000_0010);
    tick();
    lookup(32'hF000_0010, 2, "R6");
    // R8: privilege fault before permission check
    cur_ring = 1;
    lookup(32'hD000_0010, 0, "R8");
    lookup(32'hD800_0010, 2, "R8");
    cur_ring = 0;
    // R4: small-page way hit, tag 2 on ring 1
    put(0, 1, 32'h1234_5000, 32'hABCD_E000, 8'd2, 4'd6);
    cur_ring = 1;
    req_valid = 1; req_vaddr = 32'h1234_5678; req_kind = 0; cur_tag = "R4";
    tick(); req_valid = 0;
    expect_direct("R4", 2'd0, 6'd0, 32'hABCD_E678);
    tick();
    lookup(32'h1234_5678, 2, "R10");
    lookup(32'h1234_4678, 0, "R4");
    cur_ring = 0;
    // R3: tag in no ring slot
    put(1, 0, 32'h3333_0000, 32'h0011_1000, 8'h55, 4'd2);
    lookup(32'h3333_0010, 0, "R3");
    // R7: duplicate entry gives multi-hit on both sides
    put(2, 1, 32'h1234_5000, 32'h0000_0000, 8'd2, 4'd3);
    lookup(32'h1234_5000, 0, "R7");
    lookup(32'h1234_5000, 2, "R7");
    // R5: variable way with 16 MB pages
    pgsz_we = 1; pgsz_wdata = 2; tick(); pgsz_we = 0;
    put(4, 2, 32'h4200_0000, 32'h8000_0000, 8'd3, 4'd5);
    req_valid = 1; req_vaddr = 32'h42AB_CDEF; req_kind = 2; cur_tag = "R5";
    tick(); req_valid = 0;
    expect_direct("R5", 2'd0, 6'd0, 32'h80AB_CDEF);
    tick();
    lookup(32'h42AB_CDEF, 0, "R11");
    lookup(32'h42AB_CDEF, 1, "R10");
    pgsz_we = 1; pgsz_wdata = 0; tick(); pgsz_we = 0;
    lookup(32'h42AB_CDEF, 2, "R5");
    pgsz_we = 1; pgsz_wdata = 3; tick(); pgsz_we = 0;
    put(4, 0, 32'h4000_0000, 32'hC000_0000, 8'd4, 4'd1);
    lookup(32'h4321_0000, 2, "R5");
    // R2: tag register write, ring 0 byte forced to 1
    asid_we = 1; asid_wdata = 32'h0506_0700; tick(); asid_we = 0;
    lookup(32'hD000_0020, 0, "R2");
    lookup(32'h1234_5000, 0, "R2");
    put(1, 0, 32'h3333_0000, 32'h0011_1000, 8'h07, 4'd2);
    cur_ring = 1;
    lookup(32'h3333_0010, 0, "R3");
    lookup(32'h3333_0010, 1, "R3");
    cur_ring = 0;
    // R9 / R10: full attribute sweep under each access kind
    for (int a = 0; a < 16; a++) begin
      put(3, 3, 32'h7000_3000, 32'h0045_6000, 8'h06, 4'(a));
      lookup(32'h7000_3ABC, 0, "R9");
      lookup(32'h7000_3ABC, 1, "R10");
      lookup(32'h7000_3ABC, 2, "R10");
    end
    // R12: back-pressure holds the result and blocks a new request
    rsp_ready = 0;
    req_valid = 1; req_vaddr = 32'hD000_0100; req_kind = 0; cur_tag = "R12";
    tick();
    req_vaddr = 32'h7000_3004; req_kind = 2;
    repeat (3) tick();
    rsp_ready = 1;
    tick();
    req_valid = 0;
    repeat (2) tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule